// File: doc/BRIEF.md
# SPI Chip-Select and Clock Timing Sequencer

This block owns the serial clock and the chip-select lines of a master-only SPI controller. A separate frame shifter raises a request with a bit count. The sequencer accepts the request and asserts the selected chip-select line. It waits a setup delay, runs one SCK period per bit, waits a hold delay, and then either releases the line for a minimum inactive time or keeps it asserted for the next frame. A single-cycle strobe tells the shifter when to sample each bit.

All timing comes from one programmable half-period divisor. Every delay is counted in whole SCK periods, and a delay of zero inserts no extra time. Configuration is held in a small word-addressed register file written and read over a plain write-enable, address and data bus. The chip-select mode can release the line after every frame, hold it between frames, or never drive it. A per-line default register sets the idle level of each line.

Top module: `spi_cs_timer`

## Requirements
- R1: The SCK half period lasts `div + 1` input clock cycles, where `div` is the 12-bit divisor register (word 0). Upper write bits are dropped, so writing all ones reads back 0xFFF.
- R2: Clock-mode register (word 1): bit 1 sets the SCK idle level, which SCK holds whenever no frame is clocking. A frame of L bits (length 0 meaning 16) makes exactly 2L SCK transitions and L bit strobes. With bit 0 clear the strobe marks the first edge of each period (SCK at idle level in the strobe cycle); with bit 0 set it marks the second edge (SCK away from idle).
- R3: Only the line indexed by the select register (word 2) is driven away from its default. Every other line stays at its bit of the default register (word 3), so a line whose default is 0 is asserted high.
- R4: In release mode (mode register word 4 = 0), the selected line stays asserted for exactly `2*(div+1)*(c + L + h)` cycles, starting the cycle after acceptance. Here c is the setup delay in bits 7:0 of word 5 and h is the hold delay in bits 23:16 of word 5.
- R5: In release mode with a request pending, the line stays deasserted for `2*(div+1)*g + 1` cycles before the next acceptance, where g is the inactive delay in bits 7:0 of word 6.
- R6: In hold mode (mode = 2) the line stays asserted after a frame, with SCK idle. A new request is accepted at once. SCK then stays idle for the frame-gap delay (bits 23:16 of word 6) plus one half period before its first edge, and the line stays asserted throughout.
- R7: Writing release mode while in hold mode releases the line only after the current frame and its hold delay finish. If no frame is running, the line is released within two cycles.
- R8: In off mode (mode = 3) every line shows its default level while SCK still runs the full frame.
- R9: After reset: all default bits are 1, mode is release, the divisor is 3, word 5 reads 0x00010001 and word 6 reads 0x00000001. Default-register bits above the implemented line count read back as 0.
- R10: `frame_ack_o` is a one-cycle pulse. It is never raised while a frame is in progress in release mode, even with a request held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write enable |
| reg_addr_i | input | 3 | Register word index |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i` |
| frame_req_i | input | 1 | Frame request from the shifter, held until acknowledged |
| frame_len_i | input | LEN_W | Bits in the frame, 0 meaning 2**LEN_W |
| frame_ack_o | output | 1 | Request accepted this cycle |
| bit_tick_o | output | 1 | Sampling strobe, one per bit |
| sck_o | output | 1 | Serial clock |
| cs_o | output | NUM_CS | Chip-select lines |

## Verification
A wrong sequencer state or a miscounted delay counter shows up as a chip-select pulse or inactive gap that is off by a multiple of the half period. It also shows up as a wrong number of SCK transitions or strobes, all visible within the frame where the fault occurs. A wrong strobe phase appears at the very first strobe of a frame as a mismatch between SCK level and clock phase. A mode decode fault shows within two cycles, as a line that is released, held or driven against its mode.

// File: rtl/spi_cs_pkg.sv
package spi_cs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_CLOCK,
    ST_HOLD,
    ST_PARK,
    ST_GAP,
    ST_INACT
  } seq_state_e;

  localparam logic [2:0] A_DIV   = 3'd0;
  localparam logic [2:0] A_CLK   = 3'd1;
  localparam logic [2:0] A_CSID  = 3'd2;
  localparam logic [2:0] A_CSDEF = 3'd3;
  localparam logic [2:0] A_MODE  = 3'd4;
  localparam logic [2:0] A_DLY0  = 3'd5;
  localparam logic [2:0] A_DLY1  = 3'd6;

  localparam logic [1:0] CSM_AUTO = 2'd0;
  localparam logic [1:0] CSM_HOLD = 2'd2;
  localparam logic [1:0] CSM_OFF  = 2'd3;
endpackage

// File: rtl/spi_cfg_regs.sv
module spi_cfg_regs import spi_cs_pkg::*; #(
  parameter int NUM_CS  = 4,
  parameter int DIV_W   = 12,
  parameter int DLY_W   = 8,
  parameter int ID_W    = 2,
  parameter int DIV_RST = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [2:0]        addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic [DIV_W-1:0]  div_o,
  output logic              cpol_o,
  output logic              cpha_o,
  output logic [ID_W-1:0]   csid_o,
  output logic [NUM_CS-1:0] csdef_o,
  output logic [1:0]        mode_o,
  output logic [DLY_W-1:0]  cssck_o,
  output logic [DLY_W-1:0]  sckcs_o,
  output logic [DLY_W-1:0]  intercs_o,
  output logic [DLY_W-1:0]  interxfr_o
);
  logic unused_wdata;
  assign unused_wdata = ^wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_o      <= DIV_W'(DIV_RST);
      cpol_o     <= 1'b0;
      cpha_o     <= 1'b0;
      csid_o     <= '0;
      csdef_o    <= '1;
      mode_o     <= CSM_AUTO;
      cssck_o    <= DLY_W'(1);
      sckcs_o    <= DLY_W'(1);
      intercs_o  <= DLY_W'(1);
      interxfr_o <= '0;
    end else if (wr_i) begin
      case (addr_i)
        A_DIV:   div_o <= wdata_i[DIV_W-1:0];
        A_CLK:   {cpol_o, cpha_o} <= wdata_i[1:0];
        A_CSID:  csid_o <= wdata_i[ID_W-1:0];
        A_CSDEF: csdef_o <= wdata_i[NUM_CS-1:0];
        A_MODE:  mode_o <= wdata_i[1:0];
        A_DLY0: begin
          cssck_o <= wdata_i[DLY_W-1:0];
          sckcs_o <= wdata_i[16 +: DLY_W];
        end
        A_DLY1: begin
          intercs_o  <= wdata_i[DLY_W-1:0];
          interxfr_o <= wdata_i[16 +: DLY_W];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_DIV:   rdata_o[DIV_W-1:0] = div_o;
      A_CLK:   rdata_o[1:0] = {cpol_o, cpha_o};
      A_CSID:  rdata_o[ID_W-1:0] = csid_o;
      A_CSDEF: rdata_o[NUM_CS-1:0] = csdef_o;
      A_MODE:  rdata_o[1:0] = mode_o;
      A_DLY0: begin
        rdata_o[DLY_W-1:0]  = cssck_o;
        rdata_o[16 +: DLY_W] = sckcs_o;
      end
      A_DLY1: begin
        rdata_o[DLY_W-1:0]  = intercs_o;
        rdata_o[16 +: DLY_W] = interxfr_o;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/spi_sck_prescale.sv
module spi_sck_prescale #(
  parameter int DIV_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == div_i);

  // restarts whenever the sequencer is parked, so phases start aligned
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!en_i || tick_o)   cnt_q <= '0;
    else                        cnt_q <= cnt_q + DIV_W'(1);
  end
endmodule

// File: rtl/spi_cs_drive.sv
module spi_cs_drive import spi_cs_pkg::*; #(
  parameter int NUM_CS = 4,
  parameter int ID_W   = 2
) (
  input  logic              active_i,
  input  logic [1:0]        mode_i,
  input  logic [ID_W-1:0]   csid_i,
  input  logic [NUM_CS-1:0] csdef_i,
  output logic [NUM_CS-1:0] cs_o
);
  logic drive;
  assign drive = active_i && (mode_i != CSM_OFF);

  for (genvar g = 0; g < NUM_CS; g++) begin : g_line
    assign cs_o[g] = csdef_i[g] ^ (drive && (csid_i == ID_W'(g)));
  end
endmodule

// File: rtl/spi_cs_timer.sv
module spi_cs_timer import spi_cs_pkg::*; #(
  parameter int NUM_CS  = 4,
  parameter int DIV_W   = 12,
  parameter int DLY_W   = 8,
  parameter int LEN_W   = 4,
  parameter int DIV_RST = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic              frame_req_i,
  input  logic [LEN_W-1:0]  frame_len_i,
  output logic              frame_ack_o,
  output logic              bit_tick_o,
  output logic              sck_o,
  output logic [NUM_CS-1:0] cs_o
);
  localparam int ID_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1;
  localparam int CNT_W = ((DLY_W > LEN_W + 1) ? DLY_W : LEN_W + 1) + 1;

  logic [DIV_W-1:0]  sck_div;
  logic              cpol, cpha;
  logic [ID_W-1:0]   cs_id;
  logic [NUM_CS-1:0] cs_def;
  logic [1:0]        cs_mode;
  logic [DLY_W-1:0]  d_cssck, d_sckcs, d_intercs, d_interxfr;

  spi_cfg_regs #(
    .NUM_CS(NUM_CS), .DIV_W(DIV_W), .DLY_W(DLY_W), .ID_W(ID_W), .DIV_RST(DIV_RST)
  ) u_regs (
    .clk_i, .rst_ni,
    .wr_i(reg_wr_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .div_o(sck_div), .cpol_o(cpol), .cpha_o(cpha), .csid_o(cs_id), .csdef_o(cs_def),
    .mode_o(cs_mode), .cssck_o(d_cssck), .sckcs_o(d_sckcs),
    .intercs_o(d_intercs), .interxfr_o(d_interxfr)
  );

  seq_state_e       st_q, st_d, after_hold, release_st;
  logic [CNT_W-1:0] hcnt_q, target;
  logic [LEN_W-1:0] len_q;
  logic [LEN_W:0]   nbits;
  logic             sck_q, tick, half_en, last_tick, accept, cs_act, seq_idle;

  assign half_en = (st_q != ST_IDLE) && (st_q != ST_PARK);

  spi_sck_prescale #(.DIV_W(DIV_W)) u_pre (
    .clk_i, .rst_ni, .en_i(half_en), .div_i(sck_div), .tick_o(tick)
  );

  assign nbits = (len_q == '0) ? {1'b1, {LEN_W{1'b0}}} : {1'b0, len_q};

  // phase lengths in half periods
  always_comb begin
    target = '0;
    case (st_q)
      ST_SETUP: target = CNT_W'({d_cssck, 1'b0});
      ST_CLOCK: target = CNT_W'({nbits, 1'b0});
      ST_HOLD:  target = CNT_W'({d_sckcs, 1'b0});
      ST_GAP:   target = CNT_W'({d_interxfr, 1'b0});
      ST_INACT: target = CNT_W'({d_intercs, 1'b0});
      default:  target = '0;
    endcase
  end

  assign last_tick  = tick && (hcnt_q == target - CNT_W'(1));
  assign accept     = frame_req_i &&
                      ((st_q == ST_IDLE) || ((st_q == ST_PARK) && (cs_mode == CSM_HOLD)));
  assign release_st = (d_intercs != '0) ? ST_INACT : ST_IDLE;
  assign after_hold = (cs_mode == CSM_HOLD) ? ST_PARK : release_st;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE:  if (accept) st_d = (d_cssck != '0) ? ST_SETUP : ST_CLOCK;
      ST_SETUP: if (last_tick) st_d = ST_CLOCK;
      ST_CLOCK: if (last_tick) st_d = (d_sckcs != '0) ? ST_HOLD : after_hold;
      ST_HOLD:  if (last_tick) st_d = after_hold;
      ST_PARK: begin
        if (cs_mode != CSM_HOLD) st_d = release_st;
        else if (accept)         st_d = (d_interxfr != '0) ? ST_GAP : ST_CLOCK;
      end
      ST_GAP:   if (last_tick) st_d = ST_CLOCK;
      ST_INACT: if (last_tick) st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      hcnt_q <= '0;
      len_q  <= '0;
      sck_q  <= 1'b0;
    end else begin
      st_q <= st_d;
      if (st_d != st_q) hcnt_q <= '0;
      else if (tick)    hcnt_q <= hcnt_q + CNT_W'(1);
      if (accept) len_q <= frame_len_i;
      if (st_q != ST_CLOCK) sck_q <= cpol;
      else if (tick)        sck_q <= ~sck_q;
    end
  end

  // even half-period index = leading edge of the period
  assign bit_tick_o  = (st_q == ST_CLOCK) && tick && (hcnt_q[0] == cpha);
  assign frame_ack_o = accept;
  assign sck_o       = sck_q;
  assign seq_idle    = (st_q == ST_IDLE);
  assign cs_act      = (st_q == ST_SETUP) || (st_q == ST_CLOCK) || (st_q == ST_HOLD) ||
                       (st_q == ST_PARK) || (st_q == ST_GAP);

  spi_cs_drive #(.NUM_CS(NUM_CS), .ID_W(ID_W)) u_cs (
    .active_i(cs_act), .mode_i(cs_mode), .csid_i(cs_id), .csdef_i(cs_def), .cs_o(cs_o)
  );
endmodule

// File: rtl/spi_cs_timer_chk.sv
module spi_cs_timer_chk #(
  parameter int NUM_CS = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sck_o,
  input logic [NUM_CS-1:0] cs_o,
  input logic              bit_tick_o,
  input logic              frame_ack_o,
  input logic              cpol,
  input logic              cpha,
  input logic [1:0]        mode,
  input logic [NUM_CS-1:0] csdef,
  input logic              seq_idle
);
  assert_tick_phase_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_tick_o |-> ((sck_o ^ cpol) == cpha));

  assert_idle_level_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seq_idle && $stable(cpol)) |-> (sck_o == cpol));

  assert_one_line_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(cs_o ^ csdef) <= 1);

  assert_off_default_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == 2'd3) |-> (cs_o == csdef));

  assert_ack_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_ack_o |=> !frame_ack_o);
endmodule

bind spi_cs_timer spi_cs_timer_chk #(.NUM_CS(NUM_CS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sck_o(sck_o), .cs_o(cs_o),
  .bit_tick_o(bit_tick_o), .frame_ack_o(frame_ack_o),
  .cpol(cpol), .cpha(cpha), .mode(cs_mode), .csdef(cs_def), .seq_idle(seq_idle)
);

// File: tb/spi_cs_timer_test.sv
module spi_cs_timer_test;
  import spi_cs_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 5;
  // {div[12], setup[8], hold[8], inact[8], len[4], cpol, cpha, id[2], def[4]}
  localparam logic [47:0] VEC [NVEC] = '{
    {12'd0, 8'd1, 8'd1, 8'd1, 4'd8, 1'b0, 1'b0, 2'd0, 4'hF},
    {12'd1, 8'd0, 8'd0, 8'd0, 4'd4, 1'b1, 1'b1, 2'd1, 4'h5},
    {12'd2, 8'd2, 8'd3, 8'd2, 4'd5, 1'b0, 1'b1, 2'd2, 4'hF},
    {12'd0, 8'd0, 8'd2, 8'd3, 4'd0, 1'b1, 1'b0, 2'd3, 4'hA},
    {12'd3, 8'd1, 8'd0, 8'd1, 4'd1, 1'b0, 1'b0, 2'd3, 4'h0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] rdata;
  logic        req = 1'b0;
  logic [3:0]  len = '0;
  logic        ack, tick, sck;
  logic [3:0]  cs;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  spi_cs_timer uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(rdata), .frame_req_i(req),
    .frame_len_i(len), .frame_ack_o(ack), .bit_tick_o(tick), .sck_o(sck), .cs_o(cs)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = rdata;
  endtask

  task automatic wait_ack(output int n);
    n = 1;
    #1;
    while (!ack && n < 5000) begin
      @(negedge clk);
      n++;
    end
  endtask

  // called at the negedge where ack is high
  task automatic run_frame(input int id, input logic [3:0] def, input logic pol,
                           input logic pha, input bit keep, output int act,
                           output int tog, output int tks, output int bph,
                           output int bother, output int back);
    logic prev;
    prev = sck;
    act = 0; tog = 0; tks = 0; bph = 0; bother = 0; back = 0;
    @(negedge clk);
    if (!keep) req = 1'b0;
    while (cs[id] != def[id] && act < 5000) begin
      act++;
      if (sck != prev) tog++;
      prev = sck;
      if (tick) begin
        tks++;
        if ((sck ^ pol) != pha) bph++;
      end
      for (int k = 0; k < 4; k++) if (k != id && cs[k] != def[k]) bother++;
      if (ack) back++;
      @(negedge clk);
    end
    if (sck != prev) tog++;
  endtask

  initial begin
    logic [31:0] d;
    int n, act, tog, tks, bph, bo, ba;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    chk("R9 reset cs lines", int'(cs), 15);
    chk("R2 reset sck idle", int'(sck), 0);
    chk("R10 reset ack", int'(ack), 0);
    rd(A_DLY0, d);  chk("R9 reset delay0", int'(d), 32'h00010001);
    rd(A_DLY1, d);  chk("R9 reset delay1", int'(d), 1);
    rd(A_DIV, d);   chk("R9 reset divisor", int'(d), 3);
    rd(A_MODE, d);  chk("R9 reset mode", int'(d), 0);
    wr(A_CSDEF, 32'hFFFF_FFFF);
    rd(A_CSDEF, d); chk("R9 default width probe", int'(d), 15);
    wr(A_DIV, 32'hFFFF_FFFF);
    rd(A_DIV, d);   chk("R1 divisor field width", int'(d), 32'hFFF);

    // table walk in release mode
    for (int v = 0; v < NVEC; v++) begin
      int dv, c, h, g, bits, id, exp_act;
      logic pol, pha;
      logic [3:0] def;
      dv = int'(VEC[v][47:36]); c = int'(VEC[v][35:28]); h = int'(VEC[v][27:20]);
      g = int'(VEC[v][19:12]); bits = int'(VEC[v][11:8]);
      pol = VEC[v][7]; pha = VEC[v][6]; id = int'(VEC[v][5:4]); def = VEC[v][3:0];
      wr(A_DIV, 32'(dv));
      wr(A_CLK, {30'd0, pol, pha});
      wr(A_CSID, 32'(id));
      wr(A_CSDEF, {28'd0, def});
      wr(A_MODE, 32'd0);
      wr(A_DLY0, {8'd0, 8'(h), 8'd0, 8'(c)});
      wr(A_DLY1, {24'd0, 8'(g)});
      len = VEC[v][11:8];
      if (bits == 0) bits = 16;
      exp_act = 2 * (dv + 1) * (c + bits + h);
      repeat (2) @(negedge clk);
      chk("R2 idle level before frame", int'(sck), int'(pol));
      req = 1'b1;
      wait_ack(n);
      run_frame(id, def, pol, pha, 1'b1, act, tog, tks, bph, bo, ba);
      chk("R4 R1 cs active cycles", act, exp_act);
      chk("R2 sck transitions", tog, 2 * bits);
      chk("R2 bit strobes", tks, bits);
      chk("R2 strobe phase errors", bph, 0);
      chk("R3 other lines disturbed", bo, 0);
      chk("R10 ack while busy", ba, 0);
      wait_ack(n);
      chk("R5 inactive gap", n, 2 * (dv + 1) * g + 1);
      run_frame(id, def, pol, pha, 1'b0, act, tog, tks, bph, bo, ba);
      chk("R4 second frame active", act, exp_act);
      repeat (2 * g * (dv + 1) + 4) @(negedge clk);
      chk("R2 idle level after frame", int'(sck), int'(pol));
      chk("R3 lines at default", int'(cs), int'(def));
    end

    // off mode: lines at default, clock still runs
    wr(A_DIV, 32'd1); wr(A_CLK, 32'd0); wr(A_CSID, 32'd1); wr(A_CSDEF, 32'h5);
    wr(A_DLY0, 32'h0001_0001); wr(A_DLY1, 32'd1); wr(A_MODE, 32'd3);
    len = 4'd3;
    @(negedge clk);
    req = 1'b1;
    wait_ack(n);
    @(negedge clk);
    req = 1'b0;
    begin
      int t, m;
      logic prev;
      t = 0; m = 0; prev = sck;
      for (int k = 0; k < 30; k++) begin
        if (sck != prev) t++;
        prev = sck;
        if (cs != 4'h5) m++;
        @(negedge clk);
      end
      chk("R8 off mode sck transitions", t, 6);
      chk("R8 off mode lines moved", m, 0);
    end

    // hold mode: div 0, setup 1, hold 1, inactive 1, frame gap 2, 2 bits, line 2
    wr(A_DIV, 32'd0); wr(A_CSID, 32'd2); wr(A_CSDEF, 32'hF);
    wr(A_DLY0, 32'h0001_0001); wr(A_DLY1, 32'h0002_0001); wr(A_MODE, 32'd2);
    len = 4'd2;
    @(negedge clk);
    req = 1'b1;
    wait_ack(n);
    @(negedge clk);
    req = 1'b0;
    repeat (18) @(negedge clk);
    chk("R6 line held after frame", int'(cs[2]), 0);
    chk("R6 sck idle while held", int'(sck), 0);
    req = 1'b1;
    #1 chk("R6 immediate accept while held", int'(ack), 1);
    @(negedge clk);
    req = 1'b0;
    begin
      int q, drop;
      q = 0; drop = 0;
      while (sck == 1'b0 && q < 100) begin
        q++;
        if (cs[2]) drop++;
        @(negedge clk);
      end
      chk("R6 frame gap before first edge", q, 5);
      chk("R6 line dropped in gap", drop, 0);
    end
    repeat (20) @(negedge clk);
    chk("R6 line held after second frame", int'(cs[2]), 0);
    wr(A_MODE, 32'd0);
    repeat (2) @(negedge clk);
    chk("R7 release from idle hold", int'(cs[2]), 1);

    // leave hold mode during a frame
    repeat (6) @(negedge clk);
    wr(A_MODE, 32'd2);
    @(negedge clk);
    req = 1'b1;
    wait_ack(n);
    fork
      run_frame(2, 4'hF, 1'b0, 1'b0, 1'b0, act, tog, tks, bph, bo, ba);
      begin
        repeat (2) @(negedge clk);
        wr(A_MODE, 32'd0);
      end
    join
    chk("R7 release after current frame", act, 8);
    chk("R7 sck transitions", tog, 4);

    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule